// File: doc/BRIEF.md
# Serial Receiver to Parallel Link Adapter

This block sits between a gigabit serial receiver and a 32-bit parallel link destination interface. It runs on the receiver's strobe clock. On each rising edge it registers the received 20-bit word together with the receiver's frame-type, error and flag indications, and presents them as one 32-bit link word. Alongside the word it drives active-low write-enable, error and link-down strobes.

Two inputs set the operating mode: a data-width jumper (16 or 20 bits) and a flag-mode jumper. With flag mode off, the receiver's flag bit is expected to alternate between consecutive frames, and an alternation failure is merged into the error indication. With flag mode on, the flag is passed through as an extra data bit.

The four return-line inputs are sampled into the word for test purposes. The control-word output is held inactive. The reset input clears the adapter and is also forwarded as the receiver state-machine reset.

Top module: `lk_rx_adapter`

## Requirements
- R1: One clock after the inputs, the link word shows the received data on bits 19..0, zeros on bits 23..20, the return lines on bits 27..24 and the flag input on bit 28.
- R2: In 16-bit mode (`mode20_i` = 0), bits 19..16 of the link word are zero.
- R3: Bit 31 of the link word is low one clock after a control frame (`rx_cav_i` = 1) received while ready, and high otherwise.
- R4: One clock after a data or control frame (`rx_dav_i` or `rx_cav_i`) received while ready, `wen_no` is low and bit 30 carries the same value. Fill frames leave both high.
- R5: One clock after `rx_err_i` is high while ready, `err_no` is low and bit 29 carries the same value.
- R6: With flag mode off, a valid frame raises the error indication when its flag equals the flag of the previous valid frame. A valid frame is a data or control frame without `rx_err_i`. The first valid frame after reset, or after ready returns, raises no error. Fill frames and error frames do not update the reference flag.
- R7: With flag mode on (`flag_mode_i` = 1), no alternation error is raised, and bit 28 still carries the flag input.
- R8: One clock after `rx_ready_i` is low, `down_no` is low and `wen_no` and `err_no` are high. `down_no` is high one clock after ready is high.
- R9: `ctrl_no` is constantly high. `rx_sm_rst_no` equals `rst_ni`.
- R10: While `rst_ni` is low, the link word is 32'hE000_0000, `wen_no` and `err_no` are high and `down_no` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receiver strobe clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_data_i | input | 20 | Received data word |
| rx_dav_i | input | 1 | Receiver reports a data frame |
| rx_cav_i | input | 1 | Receiver reports a control frame |
| rx_err_i | input | 1 | Receiver reports an invalid encoding |
| rx_flag_i | input | 1 | Received flag bit |
| rx_ready_i | input | 1 | Receiver start-up sequence complete |
| mode20_i | input | 1 | 1: 20-bit mode, 0: 16-bit mode |
| flag_mode_i | input | 1 | 1: flag is a data bit, 0: flag alternation checked |
| ret_line_i | input | 4 | Return lines, sampled for test |
| link_word_o | output | 32 | Packed link word |
| wen_no | output | 1 | Active-low write enable |
| err_no | output | 1 | Active-low error |
| down_no | output | 1 | Active-low link down |
| ctrl_no | output | 1 | Control-word strobe, held high |
| rx_sm_rst_no | output | 1 | Active-low reset to the receiver state machine |

## Verification
The stimulus covers several flag patterns:
- Properly alternating data frames, which exercise the data path with no error.
- A repeated flag, which must produce exactly one error.
- Fill frames and erroneous frames placed between alternating frames, which show whether the reference flag is wrongly updated.
- A drop of ready, which shows whether the checker re-synchronises on the next frame.

Control, fill and erroneous frames separate the write-enable, control and error bits from one another. The same data is then replayed in 16-bit mode and in flag mode, so that masking of the upper data bits and suppression of the alternation check are each seen on their own.

// File: rtl/lk_pkg.sv
package lk_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned RL_LSB   = 24;
  localparam int unsigned FLAG_BIT = 28;
  localparam int unsigned ERR_BIT  = 29;
  localparam int unsigned WEN_BIT  = 30;
  localparam int unsigned CAV_BIT  = 31;
  localparam logic [WORD_W-1:0] WORD_RST = 32'hE000_0000;
endpackage

// File: rtl/lk_alt_check.sv
module lk_alt_check (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic frame_ok_i,
  input  logic flag_i,
  output logic alt_err_o
);
  logic have_ref_q, exp_q;

  assign alt_err_o = enable_i && frame_ok_i && have_ref_q && (flag_i != exp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_ref_q <= 1'b0;
      exp_q      <= 1'b0;
    end else if (!enable_i) begin
      have_ref_q <= 1'b0;
    end else if (frame_ok_i) begin
      have_ref_q <= 1'b1;
      exp_q      <= ~flag_i;   // resync after mismatch
    end
  end
endmodule

// File: rtl/lk_word_pack.sv
module lk_word_pack
  import lk_pkg::*;
#(
  parameter int unsigned DATA_W   = 20,
  parameter int unsigned NARROW_W = 16,
  parameter int unsigned RL_W     = 4
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              mode20_i,
  input  logic [RL_W-1:0]   rl_i,
  input  logic              flag_i,
  input  logic              err_n_i,
  input  logic              wen_n_i,
  input  logic              cav_n_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int unsigned RES_W = RL_LSB - DATA_W;
  logic [DATA_W-1:0] data_m;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    if (i < NARROW_W) begin : g_low
      assign data_m[i] = data_i[i];
    end else begin : g_high
      assign data_m[i] = data_i[i] & mode20_i;
    end
  end

  assign word_o = {cav_n_i, wen_n_i, err_n_i, flag_i, rl_i, {RES_W{1'b0}}, data_m};
endmodule

// File: rtl/lk_rx_adapter.sv
module lk_rx_adapter
  import lk_pkg::*;
#(
  parameter int unsigned DATA_W   = 20,
  parameter int unsigned NARROW_W = 16,
  parameter int unsigned RL_W     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_dav_i,
  input  logic              rx_cav_i,
  input  logic              rx_err_i,
  input  logic              rx_flag_i,
  input  logic              rx_ready_i,
  input  logic              mode20_i,
  input  logic              flag_mode_i,
  input  logic [RL_W-1:0]   ret_line_i,
  output logic [WORD_W-1:0] link_word_o,
  output logic              wen_no,
  output logic              err_no,
  output logic              down_no,
  output logic              ctrl_no,
  output logic              rx_sm_rst_no
);
  logic              frame_ok, alt_err;
  logic              wen_n_d, err_n_d, cav_n_d;
  logic [WORD_W-1:0] word_d, word_q;
  logic              wen_nq, err_nq, down_nq;

  assign frame_ok = (rx_dav_i || rx_cav_i) && !rx_err_i;

  lk_alt_check u_alt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (rx_ready_i && !flag_mode_i),
    .frame_ok_i(frame_ok),
    .flag_i    (rx_flag_i),
    .alt_err_o (alt_err)
  );

  assign wen_n_d = !(rx_ready_i && (rx_dav_i || rx_cav_i));
  assign err_n_d = !(rx_ready_i && (rx_err_i || alt_err));
  assign cav_n_d = !(rx_ready_i && rx_cav_i);

  lk_word_pack #(.DATA_W(DATA_W), .NARROW_W(NARROW_W), .RL_W(RL_W)) u_pack (
    .data_i  (rx_data_i),
    .mode20_i(mode20_i),
    .rl_i    (ret_line_i),
    .flag_i  (rx_flag_i),
    .err_n_i (err_n_d),
    .wen_n_i (wen_n_d),
    .cav_n_i (cav_n_d),
    .word_o  (word_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= WORD_RST;
      wen_nq  <= 1'b1;
      err_nq  <= 1'b1;
      down_nq <= 1'b0;
    end else begin
      word_q  <= word_d;
      wen_nq  <= wen_n_d;
      err_nq  <= err_n_d;
      down_nq <= rx_ready_i;
    end
  end

  assign link_word_o  = word_q;
  assign wen_no       = wen_nq;
  assign err_no       = err_nq;
  assign down_no      = down_nq;
  assign ctrl_no      = 1'b1;
  assign rx_sm_rst_no = rst_ni;

  AST_WEN_ON_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_i && (rx_dav_i || rx_cav_i) |=> !wen_no && !link_word_o[WEN_BIT]); // R4
  AST_ERR_ON_RXERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_ready_i && rx_err_i |=> !err_no && !link_word_o[ERR_BIT]); // R5
  AST_NO_ALT_FLAGMODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_mode_i && rx_ready_i && !rx_err_i |=> err_no); // R7
  AST_DOWN_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_ready_i |=> !down_no && wen_no && err_no); // R8
  AST_NARROW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode20_i |=> link_word_o[19:16] == 4'h0); // R2
  AST_RES_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> link_word_o[23:20] == 4'h0 && link_word_o[27:24] == $past(ret_line_i)); // R1
endmodule

// File: tb/tb_lk_rx_adapter.sv
module tb_lk_rx_adapter;
  typedef struct {
    logic [31:0] word;
    logic        wen, err, down;
    string       tag;
  } exp_t;

  logic clk = 0, rst_ni = 0;
  logic [19:0] rx_data = 0;
  logic rx_dav = 0, rx_cav = 0, rx_err = 0, rx_flag = 0, rx_ready = 0;
  logic mode20 = 1, flag_mode = 0;
  logic [3:0] ret_line = 0;
  logic [31:0] link_word;
  logic wen_no, err_no, down_no, ctrl_no, rx_sm_rst_no;

  int checks = 0, fails = 0;
  exp_t q[$];
  logic m_have = 0, m_exp = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lk_rx_adapter dut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_data_i(rx_data), .rx_dav_i(rx_dav),
    .rx_cav_i(rx_cav), .rx_err_i(rx_err), .rx_flag_i(rx_flag),
    .rx_ready_i(rx_ready), .mode20_i(mode20), .flag_mode_i(flag_mode),
    .ret_line_i(ret_line), .link_word_o(link_word), .wen_no(wen_no),
    .err_no(err_no), .down_no(down_no), .ctrl_no(ctrl_no),
    .rx_sm_rst_no(rx_sm_rst_no)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input string tag, input logic dav, input logic cav, input logic err,
                       input logic flag, input logic [19:0] d, input logic [3:0] rl,
                       input logic rdy);
    exp_t e;
    logic alt = 0;
    @(negedge clk);
    rx_dav = dav; rx_cav = cav; rx_err = err; rx_flag = flag;
    rx_data = d; ret_line = rl; rx_ready = rdy;
    if (!rdy || flag_mode) m_have = 0;
    else if ((dav || cav) && !err) begin
      alt = m_have && (flag != m_exp);
      m_exp = ~flag;
      m_have = 1;
    end
    e.wen  = !((dav || cav) && rdy);
    e.err  = !(rdy && (err || alt));
    e.down = rdy;
    e.word = {!(cav && rdy), e.wen, e.err, flag, rl, 4'h0,
              mode20 ? d[19:16] : 4'h0, d[15:0]};
    e.tag  = tag;
    @(posedge clk);
    #1 q.push_back(e);
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({e.tag, " word"}, link_word, e.word);
      chk({e.tag, " wen"}, {31'b0, wen_no}, {31'b0, e.wen});
      chk({e.tag, " err"}, {31'b0, err_no}, {31'b0, e.err});
      chk({e.tag, " down"}, {31'b0, down_no}, {31'b0, e.down});
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rx_ready = 1; rx_dav = 1; rx_data = 20'hFFFFF;
    #23;
    chk("R10 word", link_word, 32'hE000_0000);
    chk("R10 wen/err/down", {29'b0, wen_no, err_no, down_no}, 32'h6);
    chk("R9 ctrl", {31'b0, ctrl_no}, 32'h1);
    chk("R9 rst fwd low", {31'b0, rx_sm_rst_no}, 32'h0);
    @(negedge clk); rst_ni = 1; #1;
    chk("R9 rst fwd high", {31'b0, rx_sm_rst_no}, 32'h1);

    drive("R8 down", 1, 0, 1, 0, 20'h12345, 4'h3, 0);
    drive("R8 down2", 0, 1, 0, 1, 20'h00001, 4'h0, 0);
    drive("R1 first", 1, 0, 0, 0, 20'hABCDE, 4'h5, 1);
    drive("R1 alt", 1, 0, 0, 1, 20'h5A5A5, 4'hA, 1);
    drive("R3 ctrl", 0, 1, 0, 0, 20'h0F0F0, 4'hC, 1);
    drive("R4 fill", 0, 0, 0, 1, 20'h11111, 4'h1, 1);
    drive("R4 data", 1, 0, 0, 1, 20'h22222, 4'h2, 1);
    drive("R6 repeat", 1, 0, 0, 1, 20'h33333, 4'h3, 1);
    drive("R6 resync", 1, 0, 0, 0, 20'h44444, 4'h4, 1);
    drive("R6 fill keep", 0, 0, 0, 0, 20'h55555, 4'h5, 1);
    drive("R6 after fill", 1, 0, 0, 1, 20'h66666, 4'h6, 1);
    drive("R5 err frame", 1, 0, 1, 1, 20'h77777, 4'h7, 1);
    drive("R6 after err", 0, 1, 0, 0, 20'h88888, 4'h8, 1);
    drive("R8 drop", 1, 0, 0, 0, 20'h99999, 4'h9, 0);
    drive("R6 relink", 1, 0, 0, 0, 20'hAAAAA, 4'hA, 1);
    drive("R6 relink2", 1, 0, 0, 1, 20'hBBBBB, 4'hB, 1);
    mode20 = 0;
    drive("R2 narrow", 1, 0, 0, 0, 20'hFFFFF, 4'hF, 1);
    drive("R2 narrow2", 0, 1, 0, 1, 20'h9C3A1, 4'h6, 1);
    mode20 = 1;
    flag_mode = 1;
    drive("R7 flag1", 1, 0, 0, 1, 20'h13579, 4'h1, 1);
    drive("R7 flag1 again", 1, 0, 0, 1, 20'h2468A, 4'h2, 1);
    drive("R7 flag0", 0, 1, 0, 0, 20'hFEDCB, 4'h4, 1);
    drive("R7 flag0 again", 1, 0, 0, 0, 20'h0000F, 4'h8, 1);
    drive("R5 err flagmode", 1, 0, 1, 0, 20'h00F00, 4'h0, 1);
    flag_mode = 0;
    drive("R6 first after mode", 1, 0, 0, 0, 20'h31415, 4'h3, 1);
    drive("R6 repeat2", 1, 0, 0, 0, 20'h27182, 4'h7, 1);
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule